// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder

This block adds two radix-2 signed-digit numbers whose digits each take the value -1, 0 or +1. The result is a signed-digit sum one digit wider than the operands. No carry travels further than one position, so the logic depth stays the same for any operand width.

Each position first splits the pair of operand digits into a carry for the position above and an intermediate sum digit for its own position. The choice is steered by whether both digits one position lower are nonnegative. Each position then adds its intermediate sum digit to the carry arriving from below. The steering guarantees that this second addition stays inside the digit set and never produces a carry of its own.

The block is purely combinational. It is meant to sit inside a larger datapath, for example as one level of a multiplier's partial-product tree. Conversion of the result to two's complement is done elsewhere.

Top module: `sd_cf_adder`

## Requirements
- R1: Each digit uses two bits: the upper bit marks +1 and the lower bit marks -1. Code 00 is zero and code 11 is never applied. Digit i of a bus sits at bits [2i+1:2i].
- R2: The value of `sum_o` (DIGITS+1 digits) equals the value of `aug_i` plus the value of `add_i` for every pair of valid operands.
- R3: Two +1 digits at a position give carry +1 and intermediate sum 0. Two -1 digits give carry -1 and intermediate sum 0. A zero/zero pair or a +1/-1 pair gives carry 0 and intermediate sum 0.
- R4: A +1 paired with a 0 gives carry +1 and intermediate sum -1 when both lower digits are nonnegative. Otherwise it gives carry 0 and intermediate sum +1.
- R5: A -1 paired with a 0 gives carry 0 and intermediate sum -1 when both lower digits are nonnegative. Otherwise it gives carry -1 and intermediate sum +1.
- R6: Below digit 0, both operand digits are taken as zero, and so as nonnegative.
- R7: Each output digit is the intermediate sum digit plus the carry from the next lower position, with no further carry. The top output digit is the carry out of the most significant position.
- R8: Adding the plain binary forms of 87 and 101 gives a sum whose value is 188.
- R9: No output digit ever carries code 11.
- R10: Changing operand digit j can only change output digits j, j+1 and j+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aug_i | input | 2*DIGITS | First operand, signed-digit |
| add_i | input | 2*DIGITS | Second operand, signed-digit |
| sum_o | output | 2*DIGITS+2 | Sum, signed-digit, DIGITS+1 digits |

## Verification
Two things can happen at the same position together: the position chooses its own carry from the sign of the digits below it, and it absorbs the carry coming up from that same lower position. The bench makes them coincide with operands in which a +1/0 or -1/0 pair sits directly above a negative digit, and in which long runs of equal digits force a carry into every position. Each case is judged on the exact digit pattern expected at the ports and on the value of the sum against integer addition. Exhaustive 4-digit operands and random 16-digit operands reach every combination of the two.

// File: rtl/sd_add_pkg.sv
package sd_add_pkg;
  typedef logic [1:0] sd_digit_t;

  localparam sd_digit_t SD_ZERO = 2'b00;
  localparam sd_digit_t SD_POS  = 2'b10;
  localparam sd_digit_t SD_NEG  = 2'b01;

  // integer value of one digit code
  function automatic int sd_val(input sd_digit_t d);
    return (d[1] ? 1 : 0) - (d[0] ? 1 : 0);
  endfunction
endpackage

// File: rtl/sd_carry_pick.sv
// Step one: split a digit pair into carry and intermediate sum (R3, R4, R5)
module sd_carry_pick
  import sd_add_pkg::*;
(
  input  sd_digit_t aug_d,
  input  sd_digit_t add_d,
  input  logic      low_nonneg,
  output sd_digit_t carry_d,
  output sd_digit_t isum_d
);
  logic two_pos, two_neg, one_pos, one_neg;

  always_comb begin
    two_pos = (aug_d == SD_POS) && (add_d == SD_POS);
    two_neg = (aug_d == SD_NEG) && (add_d == SD_NEG);
    one_pos = ((aug_d == SD_POS) && (add_d == SD_ZERO)) ||
              ((aug_d == SD_ZERO) && (add_d == SD_POS));
    one_neg = ((aug_d == SD_NEG) && (add_d == SD_ZERO)) ||
              ((aug_d == SD_ZERO) && (add_d == SD_NEG));
  end

  always_comb begin
    carry_d = SD_ZERO;
    isum_d  = SD_ZERO;
    if (two_pos) begin
      carry_d = SD_POS;
    end else if (two_neg) begin
      carry_d = SD_NEG;
    end else if (one_pos) begin
      if (low_nonneg) begin
        carry_d = SD_POS;
        isum_d  = SD_NEG;
      end else begin
        isum_d  = SD_POS;
      end
    end else if (one_neg) begin
      if (low_nonneg) begin
        isum_d  = SD_NEG;
      end else begin
        carry_d = SD_NEG;
        isum_d  = SD_POS;
      end
    end
  end

  // R2: the split preserves the pair's value
  always_comb begin
    if (aug_d != 2'b11 && add_d != 2'b11)
      a_r2_split_identity: assert (sd_val(aug_d) + sd_val(add_d) ==
                                   2 * sd_val(carry_d) + sd_val(isum_d))
        else $error("split identity broken");
  end
endmodule

// File: rtl/sd_digit_join.sv
// Step two: intermediate sum plus carry from below, never a carry (R7)
module sd_digit_join
  import sd_add_pkg::*;
(
  input  sd_digit_t isum_d,
  input  sd_digit_t carry_in_d,
  output sd_digit_t sum_d
);
  always_comb begin
    if (isum_d == SD_ZERO)          sum_d = carry_in_d;
    else if (carry_in_d == SD_ZERO) sum_d = isum_d;
    else                            sum_d = SD_ZERO;
  end

  // R7: like-signed pairs never meet in step two
  always_comb begin
    a_r7_no_double_carry: assert (!((isum_d == SD_POS) && (carry_in_d == SD_POS)) &&
                                  !((isum_d == SD_NEG) && (carry_in_d == SD_NEG)))
      else $error("step two would need a carry");
  end
endmodule

// File: rtl/sd_cf_adder.sv
module sd_cf_adder
  import sd_add_pkg::*;
#(
  parameter int DIGITS = 16
) (
  input  logic [2*DIGITS-1:0] aug_i,
  input  logic [2*DIGITS-1:0] add_i,
  output logic [2*DIGITS+1:0] sum_o
);
  localparam int SUM_DIGITS = DIGITS + 1;

  sd_digit_t carry_w [DIGITS];
  sd_digit_t isum_w  [DIGITS];
  logic      nonneg_w[DIGITS];

  for (genvar i = 0; i < DIGITS; i++) begin : g_pos
    if (i == 0) begin : g_lsb
      assign nonneg_w[i] = 1'b1;  // R6: zeros below digit 0
    end else begin : g_up
      assign nonneg_w[i] = !aug_i[2*i-2] && !add_i[2*i-2];
    end

    sd_carry_pick u_pick (
      .aug_d     (aug_i[2*i +: 2]),
      .add_d     (add_i[2*i +: 2]),
      .low_nonneg(nonneg_w[i]),
      .carry_d   (carry_w[i]),
      .isum_d    (isum_w[i])
    );

    if (i == 0) begin : g_join0
      sd_digit_join u_join (
        .isum_d    (isum_w[i]),
        .carry_in_d(SD_ZERO),
        .sum_d     (sum_o[2*i +: 2])
      );
    end else begin : g_joinn
      sd_digit_join u_join (
        .isum_d    (isum_w[i]),
        .carry_in_d(carry_w[i-1]),
        .sum_d     (sum_o[2*i +: 2])
      );

      // R4: nonnegative lower digits can never send a negative carry
      always_comb begin
        if (nonneg_w[i])
          a_r4_carry_sign: assert (carry_w[i-1] != SD_NEG)
            else $error("negative carry under nonnegative digits");
      end
    end
  end

  assign sum_o[2*DIGITS +: 2] = carry_w[DIGITS-1];  // R7: top digit is the carry out

  // R9: every output digit holds a legal code
  for (genvar k = 0; k < SUM_DIGITS; k++) begin : g_chk
    always_comb begin
      a_r9_code_valid: assert (sum_o[2*k +: 2] != 2'b11)
        else $error("illegal output digit code");
    end
  end
endmodule

// File: tb/sd_cf_adder_bench.sv
module sd_cf_adder_bench;
  localparam int N  = 16;
  localparam int N4 = 4;
  localparam logic [1:0] Z = 2'b00, P = 2'b10, M = 2'b01;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [2*N-1:0]  aug, add;
  logic [2*N+1:0]  sum;
  logic [2*N4-1:0] aug4, add4;
  logic [2*N4+1:0] sum4;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  sd_cf_adder #(.DIGITS(N))  u_sd_cf_adder    (.aug_i(aug),  .add_i(add),  .sum_o(sum));
  sd_cf_adder #(.DIGITS(N4)) u_sd_cf_adder_n4 (.aug_i(aug4), .add_i(add4), .sum_o(sum4));

  function automatic longint vval(input logic [63:0] v, input int nd);
    longint r = 0;
    for (int i = 0; i < nd; i++)
      r += (longint'(v[2*i+1]) - longint'(v[2*i])) <<< i;
    return r;
  endfunction

  function automatic bit bad_code(input logic [63:0] v, input int nd);
    for (int i = 0; i < nd; i++) if (v[2*i +: 2] == 2'b11) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [1:0] rnd_digit();
    int r = $urandom_range(2);
    return (r == 0) ? Z : (r == 1) ? P : M;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2*N-1:0] a, input logic [2*N-1:0] b);
    @(negedge clk);
    aug = a; add = b;
    @(posedge clk);
    #1;
  endtask

  // R1, R2: zero operands give an all-zero sum
  task automatic t_zero();
    apply('0, '0);
    chk("R1 zero sum code", longint'(sum), 0);
  endtask

  // R3: like and unlike digit pairs
  task automatic t_pairs();
    apply({{(N-1){Z}}, P}, {{(N-1){Z}}, P});
    chk("R3 +1+1 digits", longint'(sum[3:0]), longint'({P, Z}));
    apply({{(N-1){Z}}, M}, {{(N-1){Z}}, M});
    chk("R3 -1-1 digits", longint'(sum[3:0]), longint'({M, Z}));
    apply({{(N-1){Z}}, P}, {{(N-1){Z}}, M});
    chk("R3 +1-1 digits", longint'(sum), 0);
  endtask

  // R4, R6: +1 with 0, lower digits nonnegative or not
  task automatic t_pos_zero();
    apply({{(N-1){Z}}, P}, '0);
    chk("R4 R6 +1/0 over zeros", longint'(sum[3:0]), longint'({P, M}));
    apply({{(N-2){Z}}, P, M}, '0);
    chk("R4 +1/0 over negative", longint'(sum[5:0]), longint'({Z, P, M}));
  endtask

  // R5: -1 with 0, lower digits nonnegative or not
  task automatic t_neg_zero();
    apply({{(N-1){Z}}, M}, '0);
    chk("R5 -1/0 over zeros", longint'(sum[3:0]), longint'({Z, M}));
    apply({{(N-2){Z}}, M, M}, '0);
    chk("R5 -1/0 over negative", longint'(sum[5:0]), longint'({M, P, M}));
  endtask

  // R7: carry out of the top position lands in the extra digit
  task automatic t_top_carry();
    apply({P, {(N-1){Z}}}, {P, {(N-1){Z}}});
    chk("R7 top digit", longint'(sum[2*N +: 2]), longint'(P));
    apply({N{M}}, {N{M}});
    chk("R7 all -1 value", vval(64'(sum), N+1), -2 * ((64'sd1 <<< N) - 1));
  endtask

  // R8: 87 + 101 written as plain binary digits
  task automatic t_example();
    logic [2*N-1:0] a = '0, b = '0;
    for (int i = 0; i < N; i++) begin
      if ((87  >> i) & 1) a[2*i +: 2] = P;
      if ((101 >> i) & 1) b[2*i +: 2] = P;
    end
    apply(a, b);
    chk("R8 87+101", vval(64'(sum), N+1), 188);
  endtask

  // R10: a changed digit only reaches three output positions
  task automatic t_locality();
    int js[6] = '{0, 1, 5, 9, 14, 15};
    foreach (js[k]) begin
      logic [2*N-1:0] a, b, a2;
      logic [2*N+1:0] s1, s2;
      int diff = 0;
      int j = js[k];
      for (int i = 0; i < N; i++) begin
        a[2*i +: 2] = rnd_digit();
        b[2*i +: 2] = rnd_digit();
      end
      a2 = a;
      a2[2*j +: 2] = (a[2*j +: 2] == P) ? M : P;
      apply(a, b);  s1 = sum;
      apply(a2, b); s2 = sum;
      for (int i = 0; i <= N; i++)
        if ((i < j || i > j + 2) && s1[2*i +: 2] != s2[2*i +: 2]) diff++;
      chk("R10 far digits unchanged", diff, 0);
    end
  endtask

  // R2, R9: all 3^8 operand pairs of the 4-digit adder
  task automatic t_exhaustive4();
    for (int k = 0; k < 6561; k++) begin
      int t = k;
      logic [2*N4-1:0] a, b;
      for (int i = 0; i < 2 * N4; i++) begin
        logic [1:0] d = (t % 3 == 0) ? Z : (t % 3 == 1) ? P : M;
        t = t / 3;
        if (i < N4) a[2*i +: 2] = d; else b[2*(i-N4) +: 2] = d;
      end
      @(negedge clk);
      aug4 = a; add4 = b;
      @(posedge clk);
      #1;
      chk("R2 4-digit value", vval(64'(sum4), N4+1),
          vval(64'(a), N4) + vval(64'(b), N4));
      chk("R9 4-digit codes", longint'(bad_code(64'(sum4), N4+1)), 0);
    end
  endtask

  // R2, R9: random 16-digit operands
  task automatic t_random16();
    for (int k = 0; k < 3000; k++) begin
      logic [2*N-1:0] a, b;
      for (int i = 0; i < N; i++) begin
        a[2*i +: 2] = rnd_digit();
        b[2*i +: 2] = rnd_digit();
      end
      apply(a, b);
      chk("R2 16-digit value", vval(64'(sum), N+1),
          vval(64'(a), N) + vval(64'(b), N));
      chk("R9 16-digit codes", longint'(bad_code(64'(sum), N+1)), 0);
    end
  endtask

  initial begin
    aug = '0; add = '0; aug4 = '0; add4 = '0;
    repeat (2) @(posedge clk);
    t_zero();
    t_pairs();
    t_pos_zero();
    t_neg_zero();
    t_top_carry();
    t_example();
    t_locality();
    t_exhaustive4();
    t_random16();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule